// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Monitor

This block keeps the atomic reservation of one processor on shared memory. When the processor performs a linked load, the monitor records the word address and marks the reservation valid. A later conditional store succeeds only if it targets that same word and no write has reached the word in between. Writes come from the processor's own conditional store, from other agents seen on a snoop port, or from an external clear. On success the monitor enables the memory write and returns 1 to the destination register. On failure it suppresses the write and returns 0, so software loops and retries.

The verdict is combinational in the cycle of the conditional store. Reservation state changes at the next clock edge. Addresses are compared on whole words, so the low byte-offset bits play no part.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, and after any later reset, no reservation is held (`rsv_valid_o`=0), and a conditional store fails.
- R2: A linked load with no clear in the same cycle sets `rsv_valid_o`=1 at the next edge. `rsv_word_o` takes the load address without its two low bits (`ll_addr_i[31:2]`).
- R3: A conditional store succeeds when all of the following hold: the reservation is valid, the store targets the reserved word, and neither a matching snoop nor a clear arrives in the same cycle. On success, in that same cycle, `sc_ok_o`=1, `sc_wr_en_o`=1 and `sc_result_o`=1.
- R4: A failing conditional store gives `sc_ok_o`=0, `sc_wr_en_o`=0 and `sc_result_o`=0 in the same cycle. Without a conditional store, all three are 0.
- R5: Every conditional store leaves the reservation invalid after the edge, whether it passed or failed, unless a linked load arrives in the same cycle.
- R6: A snoop write to the reserved word invalidates the reservation. A snoop to that word in the same cycle as the conditional store makes the store fail. A snoop to another word has no effect.
- R7: A new linked load replaces any earlier reservation.
- R8: A conditional store to any word other than the reserved one fails, even an adjacent word.
- R9: `clear_i` invalidates the reservation at the next edge. It makes a conditional store in the same cycle fail, and it overrides a linked load in the same cycle.
- R10: A linked load arriving together with a conditional store or a matching snoop wins: the new reservation is valid afterwards.
- R11: Address bits [1:0] are ignored, so any byte address inside the reserved word matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid_i | input | 1 | Linked load issued this cycle |
| ll_addr_i | input | 32 | Byte address of the linked load |
| sc_valid_i | input | 1 | Conditional store issued this cycle |
| sc_addr_i | input | 32 | Byte address of the conditional store |
| snoop_valid_i | input | 1 | Another agent writes memory this cycle |
| snoop_addr_i | input | 32 | Byte address of that write |
| clear_i | input | 1 | Drop the reservation (e.g. on exception return) |
| sc_ok_o | output | 1 | Conditional store succeeds this cycle |
| sc_wr_en_o | output | 1 | Memory write enable for the conditional store |
| sc_result_o | output | 32 | Value returned to the destination register (1 or 0) |
| rsv_valid_o | output | 1 | Reservation currently held |
| rsv_word_o | output | 30 | Reserved word address |

## Verification
The assertions take for granted that the address inputs are meaningful only while their strobe is high. They also assume that the processor issues a linked load and a conditional store in the same cycle only as a back-to-back sequence; in that case the store is judged on the old reservation. Reset is assumed synchronous and at least one cycle long. The stimulus drives every strobe and address on the falling edge and keeps each unused address at zero. It applies the simultaneous cases (store with snoop, store with clear, load with clear, load with store, load with snoop) only as single isolated cycles, so each property sees one well-defined cycle of inputs.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 2;
  localparam int WORD_W = ADDR_W - OFS_W;

  typedef logic [WORD_W-1:0] word_t;

  // Word part of a byte address.
  function automatic word_t word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  // Verdict for a conditional store.
  function automatic logic sc_verdict(input logic req, input logic held,
                                      input logic hit, input logic kill);
    return req & held & hit & ~kill;
  endfunction
endpackage

// File: rtl/llsc_word_cmp.sv
module llsc_word_cmp #(
  parameter int WORD_W = 30
) (
  input  logic              en_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              hit_o
);
  assign hit_o = en_i && (a_i == b_i);
endmodule

// File: rtl/llsc_rsv_reg.sv
module llsc_rsv_reg #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [WORD_W-1:0] set_word_i,
  input  logic              drop_i,
  input  logic              clear_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  // Priority: clear, then new linked load, then any drop event.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      word_o  <= set_word_i;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
  parameter int DATA_W = 32
) (
  input  logic              sc_req_i,
  input  logic              held_i,
  input  logic              sc_hit_i,
  input  logic              kill_i,
  output logic              ok_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] result_o
);
  import llsc_pkg::*;
  always_comb begin
    ok_o     = sc_verdict(sc_req_i, held_i, sc_hit_i, kill_i);
    wr_en_o  = ok_o;
    result_o = '0;
    result_o[0] = ok_o;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid_i,
  input  logic [ADDR_W-1:0] ll_addr_i,
  input  logic              sc_valid_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              clear_i,
  output logic              sc_ok_o,
  output logic              sc_wr_en_o,
  output logic [DATA_W-1:0] sc_result_o,
  output logic              rsv_valid_o,
  output logic [WORD_W-1:0] rsv_word_o
);
  localparam int N_CMP = 3; // 0: sc vs rsv, 1: snoop vs rsv, 2: snoop vs sc

  word_t ll_word, sc_word, sn_word;
  assign ll_word = word_of(ll_addr_i);
  assign sc_word = word_of(sc_addr_i);
  assign sn_word = word_of(snoop_addr_i);

  logic  cmp_en [N_CMP];
  word_t cmp_a  [N_CMP];
  word_t cmp_b  [N_CMP];
  logic  cmp_hit[N_CMP];

  assign cmp_en[0] = sc_valid_i;    assign cmp_a[0] = sc_word; assign cmp_b[0] = rsv_word_o;
  assign cmp_en[1] = snoop_valid_i; assign cmp_a[1] = sn_word; assign cmp_b[1] = rsv_word_o;
  assign cmp_en[2] = snoop_valid_i && sc_valid_i;
  assign cmp_a[2]  = sn_word;       assign cmp_b[2] = sc_word;

  genvar gi;
  generate
    for (gi = 0; gi < N_CMP; gi++) begin : g_cmp
      llsc_word_cmp #(.WORD_W(WORD_W)) u_cmp (
        .en_i(cmp_en[gi]), .a_i(cmp_a[gi]), .b_i(cmp_b[gi]), .hit_o(cmp_hit[gi])
      );
    end
  endgenerate

  // Named internal events (used by the checker).
  logic sc_hit_rsv, snoop_hit_rsv, snoop_hit_sc, sc_kill, rsv_drop;
  assign sc_hit_rsv    = cmp_hit[0];
  assign snoop_hit_rsv = cmp_hit[1];
  assign snoop_hit_sc  = cmp_hit[2];
  assign sc_kill       = snoop_hit_sc | clear_i;
  assign rsv_drop      = sc_valid_i | snoop_hit_rsv;

  llsc_rsv_reg #(.WORD_W(WORD_W)) u_rsv (
    .clk(clk), .rst_n(rst_n),
    .set_i(ll_valid_i), .set_word_i(ll_word),
    .drop_i(rsv_drop), .clear_i(clear_i),
    .valid_o(rsv_valid_o), .word_o(rsv_word_o)
  );

  llsc_sc_judge #(.DATA_W(DATA_W)) u_judge (
    .sc_req_i(sc_valid_i), .held_i(rsv_valid_o), .sc_hit_i(sc_hit_rsv),
    .kill_i(sc_kill), .ok_o(sc_ok_o), .wr_en_o(sc_wr_en_o), .result_o(sc_result_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ll_valid_i,
  input logic [ADDR_W-1:0] ll_addr_i,
  input logic              sc_valid_i,
  input logic              clear_i,
  input logic              sc_ok_o,
  input logic              sc_wr_en_o,
  input logic [DATA_W-1:0] sc_result_o,
  input logic              rsv_valid_o,
  input logic [WORD_W-1:0] rsv_word_o,
  input logic              snoop_hit_rsv,
  input logic              sc_hit_rsv
);
  a_r3_pass_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok_o |-> (rsv_valid_o && sc_hit_rsv && sc_valid_i));
  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_ok_o |-> (!sc_wr_en_o && sc_result_o == '0));
  a_r5_sc_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid_i && !ll_valid_i) |=> !rsv_valid_o);
  a_r6_snoop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit_rsv && !ll_valid_i) |=> !rsv_valid_o);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !rsv_valid_o);
  a_r2_ll_records: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_valid_i && !clear_i) |=> (rsv_valid_o && rsv_word_o == $past(ll_addr_i[ADDR_W-1:OFS_W])));
  a_r9_clear_kills_sc: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> !sc_ok_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ll_valid_i(ll_valid_i), .ll_addr_i(ll_addr_i),
  .sc_valid_i(sc_valid_i), .clear_i(clear_i), .sc_ok_o(sc_ok_o),
  .sc_wr_en_o(sc_wr_en_o), .sc_result_o(sc_result_o), .rsv_valid_o(rsv_valid_o),
  .rsv_word_o(rsv_word_o), .snoop_hit_rsv(snoop_hit_rsv), .sc_hit_rsv(sc_hit_rsv)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ll_v = 1'b0, sc_v = 1'b0, sn_v = 1'b0, clr = 1'b0;
  logic [31:0] ll_a = '0, sc_a = '0, sn_a = '0;
  logic        ok, wr_en, rvalid;
  logic [31:0] result;
  logic [29:0] rword;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  llsc_monitor u0 (
    .clk(clk), .rst_n(rst_n), .ll_valid_i(ll_v), .ll_addr_i(ll_a),
    .sc_valid_i(sc_v), .sc_addr_i(sc_a), .snoop_valid_i(sn_v), .snoop_addr_i(sn_a),
    .clear_i(clr), .sc_ok_o(ok), .sc_wr_en_o(wr_en), .sc_result_o(result),
    .rsv_valid_o(rvalid), .rsv_word_o(rword)
  );

  typedef struct packed {
    logic ll; logic [31:0] la;
    logic sc; logic [31:0] sa;
    logic sn; logic [31:0] na;
    logic clr; logic ok; logic vld;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R1 no reservation
    '{1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1}, // R2
    '{1'b0, 32'h0,   1'b1, 32'h103, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R3 R11 R5
    '{1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R5 already used
    '{1'b1, 32'h200, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 32'h204, 1'b0, 1'b0, 1'b1}, // R6 other word
    '{1'b0, 32'h0,   1'b1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R3
    '{1'b1, 32'h300, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 32'h302, 1'b0, 1'b0, 1'b0}, // R6 R11
    '{1'b0, 32'h0,   1'b1, 32'h300, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R6 R4
    '{1'b1, 32'h400, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b1, 32'h500, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1}, // R7
    '{1'b0, 32'h0,   1'b1, 32'h400, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R7 R8
    '{1'b1, 32'h600, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b1, 32'h600, 1'b1, 32'h601, 1'b0, 1'b0, 1'b0}, // R6 same cycle
    '{1'b1, 32'h700, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b0, 1'b0}, // R9
    '{1'b0, 32'h0,   1'b1, 32'h700, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}, // R9
    '{1'b1, 32'h800, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b1, 32'h800, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0}, // R9 same cycle
    '{1'b1, 32'h900, 1'b0, 32'h0,   1'b0, 32'h0,   1'b1, 1'b0, 1'b0}, // R9 beats ll
    '{1'b1, 32'hA00, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b1, 32'hB00, 1'b1, 32'hA00, 1'b0, 32'h0,   1'b0, 1'b1, 1'b1}, // R10
    '{1'b0, 32'h0,   1'b1, 32'hB00, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R10
    '{1'b1, 32'hC00, 1'b0, 32'h0,   1'b1, 32'hC00, 1'b0, 1'b0, 1'b1}, // R10 snoop
    '{1'b0, 32'h0,   1'b1, 32'hC02, 1'b0, 32'h0,   1'b0, 1'b1, 1'b0}, // R10 R11
    '{1'b1, 32'hD00, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,   1'b1, 32'hD04, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0}  // R8 adjacent
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ll_v = 0; sc_v = 0; sn_v = 0; clr = 0; ll_a = '0; sc_a = '0; sn_a = '0;
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset valid", {31'b0, rvalid}, 32'd0);
    chk("R4 idle ok", {31'b0, ok}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ll_v = TBL[i].ll; ll_a = TBL[i].la;
      sc_v = TBL[i].sc; sc_a = TBL[i].sa;
      sn_v = TBL[i].sn; sn_a = TBL[i].na;
      clr  = TBL[i].clr;
      #1;
      chk($sformatf("R3/R4 ok vec %0d", i), {31'b0, ok}, {31'b0, TBL[i].ok});
      chk($sformatf("R3/R4 wr_en vec %0d", i), {31'b0, wr_en}, {31'b0, TBL[i].ok});
      chk($sformatf("R3/R4 result vec %0d", i), result, {31'b0, TBL[i].ok});
      @(posedge clk); #1;
      chk($sformatf("R5 valid after vec %0d", i), {31'b0, rvalid}, {31'b0, TBL[i].vld});
      if (TBL[i].ll && !TBL[i].clr)
        chk($sformatf("R2 word vec %0d", i), {2'b0, rword}, {2'b0, TBL[i].la[31:2]});
      idle();
    end

    // R1: reset while a reservation is held
    @(negedge clk); ll_v = 1; ll_a = 32'hE00;
    @(negedge clk); idle(); #1;
    chk("R2 held before reset", {31'b0, rvalid}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 reset drops reservation", {31'b0, rvalid}, 32'd0);
    sc_v = 1; sc_a = 32'hE00; #1;
    chk("R1 sc after reset fails", {31'b0, ok}, 32'd0);
    @(negedge clk); idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule